// File: doc/BRIEF.md
# Composite Sync Combiner with Pulse-Width Deglitch

This block merges separate horizontal and vertical sync inputs into one active-low composite sync output. It uses a simple gate-style merge and then cleans the result with a clocked pulse-width filter. It suits progressive sources that feed a receiver with a single sync wire.

A mode input selects the merge method:

- **Override mode.** The output tracks horizontal sync. While vertical sync is active, the output is held in its sync state.
- **Equality mode.** The output is the inverted exclusive-OR of the two syncs, so pulses keep appearing inside the vertical interval.

Two polarity inputs state, for each sync input, whether it is active-high or active-low. Both inputs are converted to active-low internally. Each input then passes through a two-flop synchroniser into the system clock domain.

The filter holds the output until the merged level has disagreed with it for a programmable number of consecutive clocks. Short spurious pulses, such as those from near-simultaneous input edges or a shifted vertical edge, are therefore dropped. Every pulse that is kept is delayed by a fixed amount.

Top module: `csync_merge`

## Requirements
- R1: While reset is asserted, and directly after its release, `csync_n` is 1. It stays 1 until the merged level has been different from it for the filter width.
- R2: In override mode (`mode_eq`=0), with vertical sync inactive, the merged level equals the active-low horizontal sync: 0 while horizontal sync is active, 1 otherwise.
- R3: In override mode, the merged level is 0 for as long as vertical sync is active, whatever horizontal sync does.
- R4: In equality mode (`mode_eq`=1), the merged level is 1 when both syncs are active or both are inactive, and 0 when exactly one is active.
- R5: An input pin is active when it is 1 if its polarity bit (`h_pol_hi` or `v_pol_hi`) is 1, and active when it is 0 if the bit is 0. All four polarity pairs work in both modes.
- R6: A merged level that lasts fewer than W consecutive clocks never reaches `csync_n`, where W is `min_width` (or 1 when `min_width` is 0). A level that lasts W clocks or more does reach it.
- R7: When both inputs are steady and one input pin changes so that the merged level changes, `csync_n` changes on the (W+2)-th rising clock edge after the pin change. Two of these edges are spent in the synchroniser and W in the filter.
- R8: Setting `min_width` to 0 behaves exactly as `min_width` of 1: every merged level change passes, with a latency of 3 edges.
- R9: In override mode, suppose vertical sync starts a few clocks after a horizontal pulse ends. The brief inactive gap at the start of the vertical interval is removed when it is shorter than W clocks, so the output has a single low interval from the horizontal pulse through the vertical interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync pin |
| vsync_in | input | 1 | Vertical sync pin |
| h_pol_hi | input | 1 | 1: horizontal sync is active-high |
| v_pol_hi | input | 1 | 1: vertical sync is active-high |
| mode_eq | input | 1 | 0: override merge, 1: inverted-XOR merge |
| min_width | input | CW | Minimum accepted level duration in clocks (0 treated as 1) |
| csync_n | output | 1 | Active-low filtered composite sync |

## Verification
The only state in the block is the two synchroniser stages per input, the filter counter and the output flop. A fault in any of them shows at `csync_n` within W+2 clocks of the next input edge.

A wrong synchroniser value shifts or inverts every output edge. A counter that clears or wraps wrongly either lets a short pulse through or swallows a legal one. Either fault changes the output level for at least one clock, and a per-clock comparison against a behavioural model catches it on the first wrong edge. Skewed and shifted edges near the vertical interval are driven on purpose, so that short-pulse rejection is tested at the exact width boundary.

// File: rtl/csync_merge.sv
module csync_merge #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          vsync_in,
  input  logic          h_pol_hi,
  input  logic          v_pol_hi,
  input  logic          mode_eq,
  input  logic [CW-1:0] min_width,
  output logic          csync_n
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [1:0]    h_sy, v_sy;
  logic          comb;
  logic [CW-1:0] eff, flt_cnt;

  // inputs become active-low before the synchroniser, so reset means "inactive"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_sy <= 2'b11;
      v_sy <= 2'b11;
    end else begin
      h_sy <= {h_sy[0], hsync_in ^ h_pol_hi};
      v_sy <= {v_sy[0], vsync_in ^ v_pol_hi};
    end
  end

  assign comb = mode_eq ? ~(h_sy[1] ^ v_sy[1]) : (h_sy[1] & v_sy[1]);
  assign eff  = (min_width == '0) ? ONE : min_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_cnt <= '0;
      csync_n <= 1'b1;
    end else if (comb == csync_n) begin
      flt_cnt <= '0;
    end else if (flt_cnt == eff - ONE) begin
      flt_cnt <= '0;
      csync_n <= comb;
    end else begin
      flt_cnt <= flt_cnt + ONE;
    end
  end

endmodule

// File: rtl/csync_merge_chk.sv
module csync_merge_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_in,
  input logic          vsync_in,
  input logic          h_pol_hi,
  input logic          v_pol_hi,
  input logic          mode_eq,
  input logic [CW-1:0] min_width,
  input logic          comb,
  input logic [CW-1:0] flt_cnt,
  input logic          csync_n
);

  logic [1:0]    up;
  logic [CW:0]   held;
  logic          raw_last;
  logic [CW-1:0] w_eff;

  assign w_eff = (min_width == '0) ? {{(CW-1){1'b0}}, 1'b1} : min_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up       <= '0;
      held     <= '0;
      raw_last <= 1'b1;
    end else begin
      if (up != 2'd3) up <= up + 2'd1;
      raw_last <= comb;
      if (comb != raw_last) held <= {{CW{1'b0}}, 1'b1};
      else if (held != {(CW+1){1'b1}}) held <= held + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> csync_n);

  // R2
  ovr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && !mode_eq && $past(vsync_in ^ v_pol_hi, 2)) |-> comb == $past(hsync_in ^ h_pol_hi, 2));

  // R3
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && !mode_eq && !$past(vsync_in ^ v_pol_hi, 2)) |-> !comb);

  // R4
  eq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up >= 2'd2 && mode_eq) |-> comb == ($past(hsync_in ^ h_pol_hi, 2) == $past(vsync_in ^ v_pol_hi, 2)));

  // R6
  width_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csync_n != $past(csync_n)) |-> (held >= {1'b0, w_eff} && csync_n == raw_last));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) flt_cnt < w_eff);

endmodule

bind csync_merge csync_merge_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
  .h_pol_hi(h_pol_hi), .v_pol_hi(v_pol_hi), .mode_eq(mode_eq),
  .min_width(min_width), .comb(comb), .flt_cnt(flt_cnt), .csync_n(csync_n)
);

// File: tb/csync_merge_tb_top.sv
module csync_merge_tb_top;
  localparam int CLK_NS = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hs_pin = 1'b1, vs_pin = 1'b1;
  logic h_hi = 1'b0, v_hi = 1'b0, meq = 1'b0;
  logic [CW-1:0] nw = 8'd2;
  logic csync_n;

  int checks = 0, fails = 0;
  bit running = 0, done = 0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;

  csync_merge #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hs_pin), .vsync_in(vs_pin),
    .h_pol_hi(h_hi), .v_pol_hi(v_hi), .mode_eq(meq),
    .min_width(nw), .csync_n(csync_n)
  );

  bit hnq[$], vnq[$], lh[$];
  bit m_out = 1'b1;

  always @(posedge clk) begin
    bit hv, vv, lvl, flip;
    int e;
    if (!rst_n) begin
      hnq = '{1'b1, 1'b1};
      vnq = '{1'b1, 1'b1};
      lh.delete();
      m_out = 1'b1;
    end else begin
      hnq.push_back(hs_pin ^ h_hi);
      vnq.push_back(vs_pin ^ v_hi);
      hv = hnq.pop_front();
      vv = vnq.pop_front();
      lvl = meq ? (hv == vv) : (hv & vv);
      lh.push_back(lvl);
      if (lh.size() > 300) void'(lh.pop_front());
      e = (nw == 0) ? 1 : int'(nw);
      if (lh.size() >= e) begin
        flip = 1;
        for (int i = 0; i < e; i++) if (lh[lh.size()-1-i] == m_out) flip = 0;
        if (flip) m_out = lvl;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && running && !done) begin
      checks++;
      if (csync_n !== m_out) begin
        fails++;
        $display("FAIL %s: csync_n=%0b expected %0b at %0t", cur_req, csync_n, m_out, $time);
      end
    end
  end

  task automatic check(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic do_reset(bit m, bit hp, bit vp, int w);
    @(negedge clk);
    rst_n = 1'b0;
    meq = m; h_hi = hp; v_hi = vp; nw = CW'(w);
    hs_pin = hp ? 1'b0 : 1'b1;
    vs_pin = vp ? 1'b0 : 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_frame(int lines, int len, int hw, int vst, int vln, int vsk,
                           string rq_h, string rq_v);
    for (int p = 0; p < lines*len; p++) begin
      bit ha, va;
      int q;
      @(negedge clk);
      ha = (p % len) < hw;
      q = p - vsk;
      va = (q >= vst*len) && (q < (vst+vln)*len);
      cur_req = va ? rq_v : rq_h;
      hs_pin = h_hi ? ha : !ha;
      vs_pin = v_hi ? va : !va;
    end
    @(negedge clk);
    hs_pin = h_hi ? 1'b0 : 1'b1;
    vs_pin = v_hi ? 1'b0 : 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic latency(int w, string r);
    int k;
    do_reset(1'b0, 1'b0, 1'b0, w);
    cur_req = r;
    repeat (5) @(negedge clk);
    hs_pin = 1'b0;
    k = 0;
    while (k < 40) begin
      @(posedge clk);
      k++;
      #1;
      if (csync_n == 1'b0) break;
    end
    check(k == ((w == 0) ? 1 : w) + 2, r, k, ((w == 0) ? 1 : w) + 2);
    @(negedge clk);
    hs_pin = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: idle level under and after reset
    do_reset(1'b0, 1'b0, 1'b0, 2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(csync_n == 1'b1, "R1", csync_n, 1);
    rst_n = 1'b1;
    running = 1;
    repeat (4) @(negedge clk);
    check(csync_n == 1'b1, "R1", csync_n, 1);

    // R2 / R3: override mode, clean timing
    do_reset(1'b0, 1'b0, 1'b0, 2);
    run_frame(12, 40, 6, 4, 3, 0, "R2", "R3");

    // R4 / R5: equality mode, every polarity pair
    for (int c = 0; c < 4; c++) begin
      do_reset(1'b1, c[0], c[1], 2);
      run_frame(10, 40, 6, 3, 3, 0, "R5", "R4");
    end

    // R5: override mode with both syncs active-high
    do_reset(1'b0, 1'b1, 1'b1, 2);
    run_frame(10, 40, 6, 3, 3, 0, "R5", "R5");

    // R6: skewed vertical edge makes a 2-clock glitch, width 3 rejects it
    do_reset(1'b1, 1'b0, 1'b0, 3);
    run_frame(10, 40, 6, 3, 3, 2, "R6", "R6");

    // R6: width larger than the horizontal pulse drops horizontal pulses entirely
    do_reset(1'b0, 1'b0, 1'b0, 10);
    run_frame(10, 40, 6, 3, 3, 0, "R6", "R6");

    // R9: vertical shifted past the horizontal pulse by 2 clocks, width 4
    do_reset(1'b0, 1'b0, 1'b0, 4);
    run_frame(12, 40, 6, 4, 3, 8, "R9", "R9");

    // R7 / R8: latency from pin to output
    latency(5, "R7");
    latency(1, "R7");
    latency(0, "R8");

    // R8: zero width passes a 1-clock skew glitch like width 1
    do_reset(1'b1, 1'b0, 1'b0, 0);
    run_frame(8, 40, 6, 3, 2, 1, "R8", "R8");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule